// File: doc/BRIEF.md
# Coprocessor Escape and Wait Handshake

This block pairs a host-side sequencer with a coprocessor-side controller. Together they pass one operation from the host to the coprocessor and signal when it is finished. The host takes a stream of instructions, one per cycle. Each instruction is a plain instruction, an escape or a wait. An escape carries an opcode. It wakes the coprocessor, which captures the opcode and pulls the active-low TEST line low to show it is busy. The coprocessor then runs a modelled operation whose length in cycles comes from the low four bits of the opcode.

The host does not block while the coprocessor works. Plain instructions keep retiring. The host stalls only at a wait instruction, and only while TEST is low. It also stalls at a second escape issued before the first operation has finished. When the count runs out, the coprocessor drives TEST high again and pulses a completion flag. Any stalled wait or escape then goes ahead. The coprocessor has no bus port of its own, so every access it would make has to go through the host.

Top module: `cop_handoff_top`

## Requirements
- R1: An escape accepted while `test_n` is 1 stores `op_code` into the coprocessor. The stored value appears on `cop_op` after the next clock edge and holds until the next accepted escape.
- R2: `test_n` goes to 0 on the clock edge that accepts an escape.
- R3: A plain instruction (`instr_kind` 0 or 3) is never stalled, whatever the value of `test_n`. It produces `retire` = 1 with its kind on `retire_kind` after the next edge.
- R4: A wait (`instr_kind` 2) is stalled (`host_stall` = 1) in every cycle in which `test_n` is 0. It retires in the first cycle in which `test_n` is 1.
- R5: A wait issued while `test_n` is already 1 shows `host_stall` = 0 in that same cycle and retires after a single edge.
- R6: An escape (`instr_kind` 1) issued while `test_n` is 0 is stalled. It is neither retired nor accepted until `test_n` returns to 1.
- R7: After an accepted escape, `test_n` stays 0 for exactly N cycles. N is `op_code[3:0]`, except that a field of 0 gives N = 1.
- R8: `cop_done` is 1 for exactly one cycle, the cycle in which `test_n` has just returned to 1.
- R9: While and after synchronous reset (`rst` = 1), `test_n` = 1, `host_stall` = 0, `retire` = 0, `cop_done` = 0 and `cop_op` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_kind | input | 2 | 0 plain, 1 escape, 2 wait, 3 plain |
| op_code | input | OPW | Escape opcode; bits [3:0] give the cycle count |
| host_stall | output | 1 | The presented instruction cannot retire this cycle |
| test_n | output | 1 | Active-low status: 0 while the coprocessor is busy |
| retire | output | 1 | Registered pulse: an instruction retired at the last edge |
| retire_kind | output | 2 | Kind of the last retired instruction |
| cop_op | output | OPW | Opcode held by the coprocessor |
| cop_done | output | 1 | Registered one-cycle completion pulse |

## Verification
`host_stall` is combinational from the presented instruction and the registered `test_n`, so it is due in the same cycle the instruction is driven. The bench therefore samples it shortly after driving the inputs and before the next edge. `retire`, `retire_kind`, `cop_op`, `test_n` and `cop_done` all change on one edge. The bench compares them just after that edge against a cycle model that it advances on the same edge. Busy length is also measured directly, by counting the cycles in which `test_n` stays low after the accepting edge.

// File: rtl/cop_pkg.sv
package cop_pkg;
  typedef enum logic [1:0] {
    K_PLAIN = 2'd0,
    K_ESC   = 2'd1,
    K_WAIT  = 2'd2,
    K_SPARE = 2'd3
  } ikind_t;
endpackage

// File: rtl/cop_host_seq.sv
module cop_host_seq
  import cop_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       instr_valid,
  input  logic [1:0] instr_kind,
  input  logic       test_n,
  output logic       host_stall,
  output logic       esc_fire,
  output logic       retire,
  output logic [1:0] retire_kind
);
  ikind_t kind;
  logic   needs_idle;

  assign kind       = ikind_t'(instr_kind);
  assign needs_idle = (kind == K_ESC) || (kind == K_WAIT);
  assign host_stall = instr_valid && needs_idle && !test_n;
  assign esc_fire   = instr_valid && (kind == K_ESC) && !host_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      retire      <= 1'b0;
      retire_kind <= K_PLAIN;
    end else begin
      retire <= instr_valid && !host_stall;
      if (instr_valid && !host_stall) retire_kind <= instr_kind;
    end
  end

  // A wait seen while busy must not retire at the following edge
  assert_wait_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && kind == K_WAIT && !test_n) |=> !retire);
  // A plain instruction always retires at the following edge
  assert_plain_flow_R3: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (kind == K_PLAIN || kind == K_SPARE)) |=> retire);
endmodule

// File: rtl/cop_engine.sv
module cop_engine #(
  parameter int OPW  = 8,
  parameter int LENW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           esc_fire,
  input  logic [OPW-1:0] op_code,
  output logic           test_n,
  output logic           cop_done,
  output logic [OPW-1:0] cop_op
);
  logic [LENW-1:0] cnt;
  logic [LENW-1:0] len;

  assign len = (op_code[LENW-1:0] == '0) ? LENW'(1) : op_code[LENW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      test_n   <= 1'b1;
      cnt      <= '0;
      cop_done <= 1'b0;
      cop_op   <= '0;
    end else begin
      cop_done <= 1'b0;
      if (!test_n) begin
        if (cnt == LENW'(1)) begin
          test_n   <= 1'b1;
          cop_done <= 1'b1;
        end else begin
          cnt <= cnt - LENW'(1);
        end
      end
      if (esc_fire) begin
        test_n <= 1'b0;
        cnt    <= len;
        cop_op <= op_code;
      end
    end
  end

  assert_fall_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(test_n) |-> $past(esc_fire));
  assert_cnt_live_R7: assert property (@(posedge clk) disable iff (rst)
    !test_n |-> (cnt != '0));
  assert_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(test_n) |-> ($past(cnt) == LENW'(1)));
  assert_done_R8: assert property (@(posedge clk) disable iff (rst)
    cop_done |-> (test_n && $past(!test_n)));
  assert_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (test_n && !cop_done));
endmodule

// File: rtl/cop_handoff_top.sv
module cop_handoff_top #(
  parameter int OPW  = 8,
  parameter int LENW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           instr_valid,
  input  logic [1:0]     instr_kind,
  input  logic [OPW-1:0] op_code,
  output logic           host_stall,
  output logic           test_n,
  output logic           retire,
  output logic [1:0]     retire_kind,
  output logic [OPW-1:0] cop_op,
  output logic           cop_done
);
  logic esc_fire;

  cop_host_seq u_host (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_kind  (instr_kind),
    .test_n      (test_n),
    .host_stall  (host_stall),
    .esc_fire    (esc_fire),
    .retire      (retire),
    .retire_kind (retire_kind)
  );

  cop_engine #(.OPW(OPW), .LENW(LENW)) u_cop (
    .clk      (clk),
    .rst      (rst),
    .esc_fire (esc_fire),
    .op_code  (op_code),
    .test_n   (test_n),
    .cop_done (cop_done),
    .cop_op   (cop_op)
  );

  // Escape never accepted while the coprocessor is busy
  assert_no_double_R6: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && instr_kind == 2'd1 && !test_n) |=> $stable(cop_op));
endmodule

// File: tb/cop_handoff_top_tb.sv
module cop_handoff_top_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       instr_valid;
  logic [1:0] instr_kind;
  logic [7:0] op_code;
  logic       host_stall, test_n, retire, cop_done;
  logic [1:0] retire_kind;
  logic [7:0] cop_op;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic       m_test_n, m_retire, m_done;
  logic [1:0] m_rkind;
  logic [3:0] m_cnt;
  logic [7:0] m_op;
  logic       last_stall;

  always #10 clk = ~clk;

  cop_handoff_top #(.OPW(8), .LENW(4)) u_dut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_kind(instr_kind),
    .op_code(op_code), .host_stall(host_stall), .test_n(test_n),
    .retire(retire), .retire_kind(retire_kind), .cop_op(cop_op),
    .cop_done(cop_done)
  );

  function automatic logic [3:0] op_len(input logic [7:0] op);
    return (op[3:0] == 4'd0) ? 4'd1 : op[3:0];
  endfunction

  function automatic logic exp_stall(input logic v, input logic [1:0] k, input logic tn);
    return v && (k == 2'd1 || k == 2'd2) && !tn;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_test_n = 1'b1; m_retire = 1'b0; m_done = 1'b0;
    m_rkind = 2'd0; m_cnt = 4'd0; m_op = 8'd0;
  endtask

  // One cycle: drive, check the same-cycle stall, clock, check registered results
  task automatic step(input logic v, input logic [1:0] k, input logic [7:0] op);
    logic st;
    string stag;
    instr_valid = v; instr_kind = k; op_code = op;
    #2;
    st = exp_stall(v, k, m_test_n);
    if (k == 2'd1) stag = "R6 escape stall";
    else if (k == 2'd2) stag = m_test_n ? "R5 wait when idle" : "R4 wait stall";
    else stag = "R3 plain never stalls";
    if (v) check(stag, host_stall, st);
    last_stall = st;
    @(posedge clk);
    m_done = 1'b0;
    if (!m_test_n) begin
      if (m_cnt == 4'd1) begin m_test_n = 1'b1; m_done = 1'b1; end
      else m_cnt = m_cnt - 4'd1;
    end
    if (v && k == 2'd1 && !st) begin
      m_test_n = 1'b0; m_cnt = op_len(op); m_op = op;
    end
    m_retire = v && !st;
    if (m_retire) m_rkind = k;
    #1;
    check("R2 R7 test_n", test_n, m_test_n);
    check("R3 retire", retire, m_retire);
    if (m_retire) check("R3 retire_kind", retire_kind, m_rkind);
    check("R8 cop_done", cop_done, m_done);
    check("R1 cop_op", cop_op, m_op);
  endtask

  // Issue an escape from idle, then count busy cycles under plain traffic
  task automatic busy_len(input logic [7:0] op, input string tag);
    int lows = 0;
    step(1'b1, 2'd1, op);
    check("R2 low after escape edge", test_n, 0);
    while (test_n == 1'b0 && lows < 40) begin
      lows++;
      step(1'b1, 2'd0, 8'h00);
    end
    check(tag, lows, op_len(op));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic       cv;
    logic [1:0] ck;
    logic [7:0] co;
    void'($urandom(32'd4242));
    rst = 1'b1; instr_valid = 1'b0; instr_kind = 2'd0; op_code = 8'h00;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset test_n", test_n, 1);
    check("R9 reset stall", host_stall, 0);
    check("R9 reset retire", retire, 0);
    check("R9 reset done", cop_done, 0);
    check("R9 reset cop_op", cop_op, 0);
    rst = 1'b0;

    // R7 length corners: zero field, one, maximum
    busy_len(8'hA0, "R7 length field 0 gives 1");
    busy_len(8'h31, "R7 length 1");
    busy_len(8'h5F, "R7 length 15");

    // R5: wait when idle retires in one cycle
    step(1'b1, 2'd2, 8'h00);
    check("R5 wait retired", retire, 1);

    // R6: back-to-back escapes, second held until done
    step(1'b1, 2'd1, 8'h13);
    step(1'b1, 2'd1, 8'hC2);
    check("R6 second escape held", last_stall, 1);
    while (last_stall) step(1'b1, 2'd1, 8'hC2);
    check("R1 second opcode captured", cop_op, 8'hC2);

    // R4: wait behind a busy coprocessor
    while (!test_n) step(1'b1, 2'd0, 8'h00);
    step(1'b1, 2'd1, 8'h05);
    step(1'b1, 2'd2, 8'h00);
    check("R4 wait stalled while busy", last_stall, 1);
    while (last_stall) step(1'b1, 2'd2, 8'h00);
    check("R4 wait retired after release", retire_kind, 2);

    // Random mix; a stalled instruction is held unchanged
    cv = 1'b0; ck = 2'd0; co = 8'h00; last_stall = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (!last_stall) begin
        cv = ($urandom % 8) != 0;
        ck = 2'($urandom % 4);
        co = 8'($urandom);
        if (($urandom % 3) != 0) co[3:0] = 4'($urandom % 4);
      end
      step(cv, ck, co);
    end

    // R9: reset mid-operation
    step(1'b1, 2'd1, 8'h0F);
    rst = 1'b1; instr_valid = 1'b0;
    @(posedge clk); #1;
    model_reset();
    check("R9 reset while busy test_n", test_n, 1);
    check("R9 reset while busy cop_op", cop_op, 0);
    rst = 1'b0;

    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule